// File: doc/BRIEF.md
# Split-Layer Associative Memory Pattern Bank

This block is a small content-addressed pattern bank for track finding. Every stored pattern holds one coarse-bin value (a superbin) for each of seven logical detector layers. During an event, hits stream in on seven parallel input buses, one bus per logical layer, at one word per bus per clock. Each pattern keeps a sticky flag per layer that records whether any hit on that layer equalled its stored superbin. When an end-of-event flag arrives, the bank stops taking input. It then scans the patterns whose number of matched layers reaches a programmable threshold and sends their addresses out one per clock, lowest address first. It finishes with an end-of-event marker and clears all flags before the next event.

The busiest logical layer is carried by two physical comparator layers, so that it can absorb twice the hit rate without a faster clock. A registered input stage fans the seven buses out to eight physical buses. On the doubled layer, each hit is steered to exactly one of the two copies by its top bit. Both copies of every pattern hold the same superbin, and the layer counts as matched if either copy matched. Patterns are written one at a time through an address/data port that works only while the bank is collecting hits.

Top module: `am_split_bank`

## Requirements
- R1: After reset `hit_ready` is high, `road_valid` and `road_eoe` are low, and no pattern is loaded.
- R2: On each logical bus whose `hit_valid` bit is high in a cycle with `hit_ready` high, one 17-bit hit word is accepted. Bus l occupies bits [17l+16:17l] of `hit_data`.
- R3: A hit on the doubled layer (bus 0 by default) goes to physical copy A when its bit 16 is 0 and to copy B when bit 16 is 1, never to both.
- R4: A pattern write (`pat_we` with `hit_ready` high) stores the seven superbins of `pat_data` (same packing as `hit_data`) at `pat_addr`, fills both copies of the doubled layer, and marks the pattern loaded. A write while `hit_ready` is low is ignored.
- R5: The doubled layer counts as matched for a pattern when either physical copy has seen a hit equal to its superbin.
- R6: A layer's match flag stays set until the end of the event. Repeated hits on the same layer count that layer once.
- R7: A loaded pattern is a road when its number of matched logical layers is at least `road_thr`.
- R8: After an accepted `hit_eoe`, `hit_ready` is low from the next cycle on. Hits in the same cycle as the flag still count. Road addresses appear from the second clock after the flag, one per clock, in strictly ascending order.
- R9: One clock after the last road (or two clocks after the flag if there is no road), `road_eoe` pulses for one cycle and `hit_ready` is high again in that same cycle, with every match flag cleared.
- R10: A pattern that was never written is never reported, even if hits equal its reset contents.
- R11: Hits offered while `hit_ready` is low have no effect on the current or any later event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 7 | Per-bus hit qualifier |
| hit_data | input | 119 | Seven packed 17-bit hit words |
| hit_eoe | input | 1 | End of event, taken when `hit_ready` is high |
| hit_ready | output | 1 | Bank is collecting hits and accepting writes |
| road_thr | input | 3 | Minimum matched logical layers for a road |
| pat_we | input | 1 | Pattern write strobe |
| pat_addr | input | 6 | Pattern address to write |
| pat_data | input | 119 | Seven packed 17-bit superbins |
| road_valid | output | 1 | `road_addr` carries a road this cycle |
| road_addr | output | 6 | Address of the matching pattern |
| road_eoe | output | 1 | End-of-event marker on the road bus |

## Verification
The assertions assume that `road_thr` does not change while roads are being read out, since the ascending-order and road-count properties compare readout cycles with each other. They also assume that nothing enters the match logic between the end-of-event flag and the readout marker, which the internal stall guarantees whatever the source drives. The stimulus changes the threshold only while `hit_ready` is high. It deliberately drives hits and pattern writes during readout to show that they are dropped. It uses superbin values that are unique per pattern and layer, so every expected road comes from the hits that were sent.

// File: rtl/am_bank_pkg.sv
package am_bank_pkg;

   typedef enum logic {
      ST_COLLECT = 1'b0,
      ST_READOUT = 1'b1
   } bank_state_e;

   // physical comparator index of a logical layer; the split layer owns two slots
   function automatic int unsigned phys_of(int unsigned lay, int unsigned split);
      return (lay > split) ? lay + 1 : lay;
   endfunction

   // logical layer feeding a physical comparator slot
   function automatic int unsigned log_of(int unsigned phys, int unsigned split);
      return (phys > split) ? phys - 1 : phys;
   endfunction

endpackage

// File: rtl/am_hit_fanout.sv
module am_hit_fanout
   import am_bank_pkg::*;
#(
   parameter int NUM_LAYERS  = 7,
   parameter int HIT_W       = 17,
   parameter int SPLIT_LAYER = 0,
   localparam int NPH        = NUM_LAYERS + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic [NUM_LAYERS-1:0] hit_valid,
   input  logic [HIT_W-1:0]      hit_word [NUM_LAYERS],
   input  logic                  eoe_in,
   output logic [NPH-1:0]        ph_valid,
   output logic [HIT_W-1:0]      ph_word [NPH],
   output logic                  eoe_q
);

   logic [NPH-1:0]   pv_d;
   logic [HIT_W-1:0] pw_d [NPH];

   always_comb begin
      pv_d = '0;
      for (int p = 0; p < NPH; p++) pw_d[p] = hit_word[log_of(p, SPLIT_LAYER)];
      for (int l = 0; l < NUM_LAYERS; l++) begin
         if (l == SPLIT_LAYER) begin
            if (hit_word[l][HIT_W-1]) pv_d[l+1] = take & hit_valid[l];
            else                      pv_d[l]   = take & hit_valid[l];
         end else begin
            pv_d[phys_of(l, SPLIT_LAYER)] = take & hit_valid[l];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_valid <= '0;
         eoe_q    <= 1'b0;
         for (int p = 0; p < NPH; p++) ph_word[p] <= '0;
      end else begin
         ph_valid <= pv_d;
         eoe_q    <= take & eoe_in;
         for (int p = 0; p < NPH; p++) ph_word[p] <= pw_d[p];
      end
   end

   // R3
   split_hi_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_valid[SPLIT_LAYER+1] |-> $past(hit_valid[SPLIT_LAYER] && hit_word[SPLIT_LAYER][HIT_W-1]));
   // R3
   split_lo_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_valid[SPLIT_LAYER] |-> $past(hit_valid[SPLIT_LAYER] && !hit_word[SPLIT_LAYER][HIT_W-1]));

endmodule

// File: rtl/am_pattern_row.sv
module am_pattern_row
   import am_bank_pkg::*;
#(
   parameter int NUM_LAYERS  = 7,
   parameter int HIT_W       = 17,
   parameter int SPLIT_LAYER = 0,
   localparam int NPH        = NUM_LAYERS + 1,
   localparam int CW         = $clog2(NUM_LAYERS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [HIT_W-1:0] wr_sb [NUM_LAYERS],
   input  logic [NPH-1:0]   ph_valid,
   input  logic [HIT_W-1:0] ph_word [NPH],
   input  logic             clr,
   input  logic [CW-1:0]    thr,
   output logic             is_road
);

   logic [HIT_W-1:0] sb [NPH];
   logic [NPH-1:0]   seen;
   logic             loaded;
   logic [CW-1:0]    layer_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded <= 1'b0;
         seen   <= '0;
         for (int p = 0; p < NPH; p++) sb[p] <= '0;
      end else begin
         if (wr) loaded <= 1'b1;
         for (int p = 0; p < NPH; p++) begin
            if (wr) sb[p] <= wr_sb[log_of(p, SPLIT_LAYER)];
            if (clr) seen[p] <= 1'b0;
            else if (ph_valid[p] && ph_word[p] == sb[p]) seen[p] <= 1'b1;
         end
      end
   end

   always_comb begin
      layer_cnt = '0;
      for (int l = 0; l < NUM_LAYERS; l++) begin
         if (l == SPLIT_LAYER)
            layer_cnt = layer_cnt + CW'(seen[l] | seen[l+1]);
         else
            layer_cnt = layer_cnt + CW'(seen[phys_of(l, SPLIT_LAYER)]);
      end
   end

   assign is_road = loaded && (layer_cnt >= thr);

   // R4
   twin_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sb[SPLIT_LAYER] == sb[SPLIT_LAYER+1]);
   // R6
   sticky_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> ((seen & $past(seen)) == $past(seen)));
   // R9
   clear_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (seen == '0));

endmodule

// File: rtl/am_road_scan.sv
module am_road_scan #(
   parameter int NUM_PATT = 64,
   localparam int AW      = $clog2(NUM_PATT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic [NUM_PATT-1:0] road_vec,
   output logic                finish,
   output logic                road_valid,
   output logic [AW-1:0]       road_addr,
   output logic                road_eoe
);

   logic [NUM_PATT-1:0] done_q;
   logic [NUM_PATT-1:0] pend;
   logic [AW-1:0]       pick;
   logic                any;

   always_comb begin
      pend = road_vec & ~done_q;
      pick = '0;
      any  = 1'b0;
      for (int i = NUM_PATT - 1; i >= 0; i--) begin
         if (pend[i]) begin
            pick = AW'(i);
            any  = 1'b1;
         end
      end
   end

   assign finish = active & ~any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q     <= '0;
         road_valid <= 1'b0;
         road_addr  <= '0;
         road_eoe   <= 1'b0;
      end else begin
         road_valid <= active & any;
         road_eoe   <= finish;
         road_addr  <= (active & any) ? pick : '0;
         if (finish)            done_q <= '0;
         else if (active & any) done_q <= done_q | (NUM_PATT'(1) << pick);
      end
   end

   // R8
   ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (road_valid && $past(road_valid)) |-> (road_addr > $past(road_addr)));
   // R9
   marker_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({road_valid, road_eoe}));

endmodule

// File: rtl/am_split_bank.sv
module am_split_bank
   import am_bank_pkg::*;
#(
   parameter int NUM_LAYERS  = 7,
   parameter int HIT_W       = 17,
   parameter int NUM_PATT    = 64,
   parameter int SPLIT_LAYER = 0,
   localparam int NPH        = NUM_LAYERS + 1,
   localparam int AW         = $clog2(NUM_PATT),
   localparam int CW         = $clog2(NUM_LAYERS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LAYERS-1:0]       hit_valid,
   input  logic [NUM_LAYERS*HIT_W-1:0] hit_data,
   input  logic                        hit_eoe,
   output logic                        hit_ready,
   input  logic [CW-1:0]               road_thr,
   input  logic                        pat_we,
   input  logic [AW-1:0]               pat_addr,
   input  logic [NUM_LAYERS*HIT_W-1:0] pat_data,
   output logic                        road_valid,
   output logic [AW-1:0]               road_addr,
   output logic                        road_eoe
);

   if (NUM_LAYERS < 2)                 begin : g_bad_layers $error("NUM_LAYERS must be at least 2"); end
   if (SPLIT_LAYER >= NUM_LAYERS)      begin : g_bad_split  $error("SPLIT_LAYER out of range"); end
   if (NUM_PATT < 2)                   begin : g_bad_patt   $error("NUM_PATT must be at least 2"); end
   if (HIT_W < 2)                      begin : g_bad_width  $error("HIT_W must be at least 2"); end

   bank_state_e         state;
   logic [HIT_W-1:0]    hit_word [NUM_LAYERS];
   logic [HIT_W-1:0]    wr_word  [NUM_LAYERS];
   logic [NPH-1:0]      ph_valid;
   logic [HIT_W-1:0]    ph_word  [NPH];
   logic                eoe_q;
   logic                finish;
   logic [NUM_PATT-1:0] road_vec;

   always_comb begin
      for (int l = 0; l < NUM_LAYERS; l++) begin
         hit_word[l] = hit_data[l*HIT_W +: HIT_W];
         wr_word[l]  = pat_data[l*HIT_W +: HIT_W];
      end
   end

   assign hit_ready = (state == ST_COLLECT) && !eoe_q;

   am_hit_fanout #(
      .NUM_LAYERS (NUM_LAYERS),
      .HIT_W      (HIT_W),
      .SPLIT_LAYER(SPLIT_LAYER)
   ) i_fanout (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (hit_ready),
      .hit_valid(hit_valid),
      .hit_word (hit_word),
      .eoe_in   (hit_eoe),
      .ph_valid (ph_valid),
      .ph_word  (ph_word),
      .eoe_q    (eoe_q)
   );

   for (genvar g = 0; g < NUM_PATT; g++) begin : g_row
      am_pattern_row #(
         .NUM_LAYERS (NUM_LAYERS),
         .HIT_W      (HIT_W),
         .SPLIT_LAYER(SPLIT_LAYER)
      ) i_row (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (pat_we && hit_ready && (pat_addr == AW'(g))),
         .wr_sb   (wr_word),
         .ph_valid(ph_valid),
         .ph_word (ph_word),
         .clr     (finish),
         .thr     (road_thr),
         .is_road (road_vec[g])
      );
   end

   am_road_scan #(
      .NUM_PATT(NUM_PATT)
   ) i_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (state == ST_READOUT),
      .road_vec  (road_vec),
      .finish    (finish),
      .road_valid(road_valid),
      .road_addr (road_addr),
      .road_eoe  (road_eoe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_COLLECT;
      end else begin
         case (state)
            ST_COLLECT: if (eoe_q)  state <= ST_READOUT;
            ST_READOUT: if (finish) state <= ST_COLLECT;
            default:                state <= ST_COLLECT;
         endcase
      end
   end

   // R8
   stall_on_eoe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ready && hit_eoe) |=> !hit_ready);
   // R8
   busy_during_roads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      road_valid |-> !hit_ready);
   // R9
   reopen_at_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      road_eoe |-> hit_ready);

endmodule

// File: tb/test_am_split_bank.sv
`timescale 1ns/1ps
module test_am_split_bank;

   localparam int NL = 7;
   localparam int HW = 17;
   localparam int NP = 64;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NL-1:0]  hv = '0;
   logic [HW-1:0]  hw [NL];
   logic [HW-1:0]  pw [NL];
   logic [NL*HW-1:0] hit_data, pat_data;
   logic           heoe = 1'b0;
   logic           hit_ready;
   logic [2:0]     thr = 3'd7;
   logic           we = 1'b0;
   logic [5:0]     waddr = '0;
   logic           road_valid, road_eoe;
   logic [5:0]     road_addr;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   always_comb begin
      for (int l = 0; l < NL; l++) begin
         hit_data[l*HW +: HW] = hw[l];
         pat_data[l*HW +: HW] = pw[l];
      end
   end

   am_split_bank i_am_split_bank (
      .clk(clk), .rst_n(rst_n), .hit_valid(hv), .hit_data(hit_data), .hit_eoe(heoe),
      .hit_ready(hit_ready), .road_thr(thr), .pat_we(we), .pat_addr(waddr),
      .pat_data(pat_data), .road_valid(road_valid), .road_addr(road_addr), .road_eoe(road_eoe)
   );

   // superbin of pattern p on layer l; layer 0 (doubled) takes bit 16 from p's parity
   function automatic logic [HW-1:0] sbv(int p, int l);
      return {(l == 0) ? 1'(p % 2) : 1'b0, 16'(p * 16 + l)};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [HW-1:0] m_sb [NP][NL];
   bit m_loaded [NP];
   bit m_hit [NP][NL];
   bit m_sent [NP];
   logic [HW-1:0] q_word [NL];
   bit q_v [NL];
   bit q_eoe, m_scan, e_rv, e_eoe;
   int e_ra;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NP; p++) begin
            m_loaded[p] = 0; m_sent[p] = 0;
            for (int l = 0; l < NL; l++) begin m_sb[p][l] = '0; m_hit[p][l] = 0; end
         end
         for (int l = 0; l < NL; l++) begin q_v[l] = 0; q_word[l] = '0; end
         q_eoe = 0; m_scan = 0; e_rv = 0; e_eoe = 0; e_ra = 0;
      end else begin
         bit ready_now;
         ready_now = !m_scan && !q_eoe;
         e_rv = 0; e_eoe = 0; e_ra = 0;
         if (m_scan) begin
            int found;
            found = -1;
            for (int p = 0; p < NP; p++) begin
               int c;
               c = 0;
               for (int l = 0; l < NL; l++) c += m_hit[p][l];
               if (found < 0 && m_loaded[p] && !m_sent[p] && c >= thr) found = p;
            end
            if (found >= 0) begin
               e_rv = 1; e_ra = found; m_sent[found] = 1;
            end else begin
               e_eoe = 1; m_scan = 0;
               for (int p = 0; p < NP; p++) begin
                  m_sent[p] = 0;
                  for (int l = 0; l < NL; l++) m_hit[p][l] = 0;
               end
            end
         end else begin
            for (int l = 0; l < NL; l++)
               if (q_v[l])
                  for (int p = 0; p < NP; p++)
                     if (q_word[l] == m_sb[p][l]) m_hit[p][l] = 1;
            if (q_eoe) m_scan = 1;
         end
         if (ready_now && we) begin
            m_loaded[waddr] = 1;
            for (int l = 0; l < NL; l++) m_sb[waddr][l] = pw[l];
         end
         for (int l = 0; l < NL; l++) begin
            q_v[l] = ready_now && hv[l];
            q_word[l] = hw[l];
         end
         q_eoe = ready_now && heoe;
      end
   end

   // ---------------- per-clock comparison ----------------
   int exp_cnt [$];
   string exp_tag [$];
   int seen_cnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         check("R8 ready", 32'(hit_ready), 32'(!m_scan && !q_eoe));
         check("R7 R8 road_valid", 32'(road_valid), 32'(e_rv));
         if (e_rv) check("R8 road_addr order", 32'(road_addr), 32'(e_ra));
         check("R9 road_eoe", 32'(road_eoe), 32'(e_eoe));
         if (road_valid) seen_cnt++;
         if (road_eoe) begin
            if (exp_cnt.size() == 0) begin
               check("R9 unexpected marker", 32'(1), 32'(0));
            end else begin
               int ec; string tg;
               ec = exp_cnt.pop_front(); tg = exp_tag.pop_front();
               check(tg, 32'(seen_cnt), 32'(ec));
            end
            seen_cnt = 0;
         end
      end
   end

   task automatic finish_sim();
      if (!done_flag) begin
         done_flag = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         checks++; errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         finish_sim();
      end
   end

   // ---------------- stimulus helpers (all called at a falling edge) ----------------
   task automatic step(logic eoe);
      heoe = eoe;
      @(negedge clk);
      hv = '0; heoe = 1'b0; we = 1'b0;
   endtask

   task automatic wait_ready();
      while (!hit_ready) @(negedge clk);
   endtask

   task automatic send_mask(int p, logic [NL-1:0] m, logic eoe);
      for (int l = 0; l < NL; l++) hw[l] = sbv(p, l);
      hv = m;
      step(eoe);
   endtask

   task automatic load(int p);
      waddr = 6'(p);
      for (int l = 0; l < NL; l++) pw[l] = sbv(p, l);
      we = 1'b1;
      step(1'b0);
   endtask

   task automatic expect_event(int n, string tag);
      exp_cnt.push_back(n);
      exp_tag.push_back(tag);
   endtask

   initial begin
      for (int l = 0; l < NL; l++) begin hw[l] = '0; pw[l] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      check("R1 ready after reset", 32'(hit_ready), 32'(1));
      check("R1 no road after reset", 32'({road_valid, road_eoe}), 32'(0));

      for (int p = 0; p < 40; p++) load(p);

      // R3 R5: both split copies (p5 bit16=1, p12 bit16=0), sent out of order, flag with last hits
      thr = 3'd7;
      expect_event(2, "R3 R5 full-match roads");
      send_mask(12, 7'h7F, 1'b0);
      send_mask(5, 7'h7F, 1'b1);
      // R11 and R4: hits and a write offered while stalled
      for (int l = 0; l < NL; l++) begin hw[l] = sbv(30, l); pw[l] = sbv(45, l); end
      hv = 7'h7F; we = 1'b1; waddr = 6'd45;
      while (!hit_ready) @(negedge clk);
      hv = '0; we = 1'b0;

      // R11 R4: stale p30 hits must not count; ignored write left p45 unloaded
      expect_event(0, "R11 R4 stalled input ignored");
      send_mask(45, 7'h7F, 1'b1);

      // R10: zeros equal unloaded rows' contents; p7 lacks the split layer
      wait_ready();
      expect_event(1, "R10 R5 unloaded and partial");
      send_mask(7, 7'b1111110, 1'b0);
      send_mask(9, 7'h7F, 1'b0);
      for (int l = 0; l < NL; l++) hw[l] = '0;
      hv = 7'h7F;
      step(1'b1);

      // R6 R7: threshold 5, repeated hits counted once
      wait_ready();
      thr = 3'd5;
      expect_event(1, "R6 R7 threshold five");
      send_mask(3, 7'b0011111, 1'b0);
      send_mask(4, 7'b0001111, 1'b0);
      send_mask(20, 7'b0000010, 1'b0);
      send_mask(20, 7'b0000010, 1'b0);
      send_mask(20, 7'b0000010, 1'b0);
      send_mask(20, 7'b0001100, 1'b1);

      // R4: legal write while idle
      wait_ready();
      thr = 3'd7;
      load(41);
      expect_event(1, "R4 written pattern found");
      send_mask(41, 7'h7F, 1'b1);

      // R2: all buses busy, threshold 1, long readout burst
      wait_ready();
      thr = 3'd1;
      expect_event(41, "R2 burst of roads");
      for (int c = 0; c < 6; c++) begin
         hv = '0;
         for (int b = 0; b < NL; b++) begin
            int p;
            p = c * 7 + b;
            hw[b] = sbv(p, b);
            if (p <= 41 && p != 40) hv[b] = 1'b1;
         end
         step(c == 5);
      end

      // R9: event without hits gives only the marker
      wait_ready();
      expect_event(0, "R9 empty event");
      step(1'b1);

      wait_ready();
      repeat (4) @(negedge clk);
      check("R9 all events closed", 32'(exp_cnt.size()), 32'(0));
      finish_sim();
   end

endmodule